// File: doc/BRIEF.md
# Virtual Register Access Sequencer

This block sits on the host side of a two-wire link to a sensor that exposes only three physical registers. The sensor's firmware keeps a larger set of registers that the host cannot address directly. The sequencer turns one command into the physical steps needed to reach one of those firmware registers. A command names a 7-bit virtual register and says whether to read or write it. The sequencer then issues physical register transactions through a simple request/response port. The bit-level bus engine sits behind that port.

A command moves through a fixed sequence. Every byte pushed into the sensor's inbound register must wait until the sensor reports that its previous inbound byte has been consumed. A read must also wait until the sensor reports that an outbound byte is ready. All waiting is done by reading the status register. Each wait has a bounded number of attempts. When a wait runs out of attempts, the command ends with an error flag. When the command ends, a one-cycle done pulse returns the result, and the command port opens again.

Top module: `vra_sequencer`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done` is 0 and `bus_req_valid` is 0.
- R2: Physical requests only target register 0x00 (status, always read), 0x01 (inbound byte, always written) or 0x02 (outbound byte, always read). While `bus_req_valid` is high and `bus_req_ready` is low, the request's write flag, address and data hold steady.
- R3: Every write to register 0x01 comes right after a status read whose bit 1 (inbound-pending) was 0. Status is read repeatedly until that happens.
- R4: A virtual write sends the address byte with bit 7 set to 0x01, waits again for bit 1 to clear, and then sends the data byte to 0x01. It ends with `done`=1, `done_err`=0 and `rdata`=0.
- R5: A virtual read sends the address byte with bit 7 clear to 0x01. It then reads status until bit 0 (outbound-ready) is 1, reads one byte from 0x02, and presents it on `rdata` in the `done` cycle with `done_err`=0.
- R6: Bit 7 of `cmd_addr` is ignored. Only bits 6..0 select the virtual register, and bit 7 of the address byte comes only from `cmd_write`.
- R7: Each wait allows at most `MAX_POLLS` status reads. If all of them show not-ready, the command aborts after exactly that many reads, with `done`=1, `done_err`=1 and `rdata`=0, and the sequencer makes no further physical requests. Readiness seen on the last allowed read counts as success. The budget restarts for every wait.
- R8: `cmd_ready` goes low in the cycle after a command is accepted and comes back high only in the cycle where `done` is 1. A command held valid is accepted at that edge.
- R9: `done` is a single-cycle pulse per command, and `done_err` is high only together with `done`.
- R10: At most one physical transaction is outstanding. No new request is raised until the response to the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command accepted when both high |
| cmd_write | input | 1 | 1 = virtual write, 0 = virtual read |
| cmd_addr | input | DATA_W | Virtual register index (bit 7 ignored) |
| cmd_wdata | input | DATA_W | Data for a virtual write |
| done | output | 1 | Command finished (one cycle) |
| done_err | output | 1 | Command aborted by poll budget |
| rdata | output | DATA_W | Read result, valid with done |
| bus_req_valid | output | 1 | Physical request present |
| bus_req_ready | input | 1 | Bus engine takes the request |
| bus_req_write | output | 1 | 1 = physical write |
| bus_req_addr | output | 8 | Physical register address |
| bus_req_wdata | output | DATA_W | Physical write byte |
| bus_rsp_valid | input | 1 | Physical transaction completed |
| bus_rsp_rdata | input | DATA_W | Byte returned by a physical read |

## Verification
Two things can land in the same cycle. The first is the poll budget running out, and the sensor turning ready on that very status read. The bench drives the status model so that readiness appears on read `MAX_POLLS` in one case and on read `MAX_POLLS`+1 in the other. It expects success in the first case and an abort after exactly `MAX_POLLS` reads in the second. The second pair is the done pulse and the acceptance of the next command. The bench holds `cmd_valid` high across back-to-back commands, and the scoreboard requires every done, in order, with `cmd_ready` already high in each done cycle.

// File: rtl/vra_pkg.sv
package vra_pkg;

    // Physical register addresses of the sensor
    localparam logic [7:0] REG_STATUS  = 8'h00;
    localparam logic [7:0] REG_INBOUND = 8'h01;
    localparam logic [7:0] REG_OUTBND  = 8'h02;

    // Status bit positions
    localparam int TX_PEND_BIT = 1;
    localparam int RX_RDY_BIT  = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_TX_A,
        ST_PUT_ADDR,
        ST_WAIT_TX_D,
        ST_PUT_DATA,
        ST_WAIT_RX,
        ST_GET_DATA
    } seq_state_e;

    typedef enum logic [1:0] {
        TP_IDLE,
        TP_REQ,
        TP_RSP
    } txn_state_e;

endpackage

// File: rtl/vra_poll_budget.sv
module vra_poll_budget #(
    parameter int MAX_POLLS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic miss,
    output logic last
);
    localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_POLLS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign last = (cnt_q == LAST_VAL);

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (miss && !last) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/vra_txn_port.sv
module vra_txn_port
    import vra_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic [7:0]        start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    output logic              idle,
    output logic              fin,
    output logic              bus_req_valid,
    input  logic              bus_req_ready,
    output logic              bus_req_write,
    output logic [7:0]        bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_rsp_valid
);
    typedef struct packed {
        txn_state_e        st;
        logic              wr;
        logic [7:0]        addr;
        logic [DATA_W-1:0] wdata;
    } txn_regs_t;

    txn_regs_t d, q;

    assign idle          = (q.st == TP_IDLE);
    assign bus_req_valid = (q.st == TP_REQ);
    assign bus_req_write = q.wr;
    assign bus_req_addr  = q.addr;
    assign bus_req_wdata = q.wdata;

    always_comb begin
        d   = q;
        fin = 1'b0;
        case (q.st)
            TP_IDLE: begin
                if (start) begin
                    d.st    = TP_REQ;
                    d.wr    = start_wr;
                    d.addr  = start_addr;
                    d.wdata = start_wdata;
                end
            end
            TP_REQ: begin
                if (bus_req_ready) begin
                    d.st = TP_RSP;
                end
            end
            TP_RSP: begin
                if (bus_rsp_valid) begin
                    d.st = TP_IDLE;
                    fin  = 1'b1;
                end
            end
            default: d.st = TP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: TP_IDLE, wr: 1'b0, addr: '0, wdata: '0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/vra_sequencer.sv
module vra_sequencer
    import vra_pkg::*;
#(
    parameter int MAX_POLLS = 16,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [DATA_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              done,
    output logic              done_err,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_req_valid,
    input  logic              bus_req_ready,
    output logic              bus_req_write,
    output logic [7:0]        bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_rsp_valid,
    input  logic [DATA_W-1:0] bus_rsp_rdata
);
    localparam logic [DATA_W-1:0] WR_FLAG    = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] INDEX_MASK = ~WR_FLAG;

    typedef struct packed {
        seq_state_e        state;
        logic              issued;
        logic              wr;
        logic [DATA_W-1:0] vaddr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              err;
    } seq_regs_t;

    seq_regs_t d, q;

    logic              t_start, t_wr, t_idle, t_fin;
    logic [7:0]        t_addr;
    logic [DATA_W-1:0] t_wdata;
    logic              pb_clear, pb_miss, pb_last;
    logic              tx_pend, rx_rdy;

    assign tx_pend = bus_rsp_rdata[TX_PEND_BIT];
    assign rx_rdy  = bus_rsp_rdata[RX_RDY_BIT];

    vra_txn_port #(.DATA_W(DATA_W)) u_txn (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (t_start),
        .start_wr      (t_wr),
        .start_addr    (t_addr),
        .start_wdata   (t_wdata),
        .idle          (t_idle),
        .fin           (t_fin),
        .bus_req_valid (bus_req_valid),
        .bus_req_ready (bus_req_ready),
        .bus_req_write (bus_req_write),
        .bus_req_addr  (bus_req_addr),
        .bus_req_wdata (bus_req_wdata),
        .bus_rsp_valid (bus_rsp_valid)
    );

    vra_poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (pb_clear),
        .miss  (pb_miss),
        .last  (pb_last)
    );

    assign cmd_ready = (q.state == ST_IDLE);
    assign done      = q.done;
    assign done_err  = q.err;
    assign rdata     = q.rdata;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = 1'b0;
        t_start  = 1'b0;
        t_wr     = 1'b0;
        t_addr   = REG_STATUS;
        t_wdata  = '0;
        pb_clear = 1'b0;
        pb_miss  = 1'b0;

        // physical transaction selected by the current step
        case (q.state)
            ST_PUT_ADDR: begin
                t_wr    = 1'b1;
                t_addr  = REG_INBOUND;
                t_wdata = q.wr ? (q.vaddr | WR_FLAG) : q.vaddr;
            end
            ST_PUT_DATA: begin
                t_wr    = 1'b1;
                t_addr  = REG_INBOUND;
                t_wdata = q.wdata;
            end
            ST_GET_DATA: begin
                t_addr  = REG_OUTBND;
            end
            default: begin
                t_addr  = REG_STATUS;
            end
        endcase

        if (q.state != ST_IDLE && !q.issued && t_idle) begin
            t_start  = 1'b1;
            d.issued = 1'b1;
        end

        if (q.state == ST_IDLE) begin
            if (cmd_valid) begin
                d.state  = ST_WAIT_TX_A;
                d.wr     = cmd_write;
                d.vaddr  = cmd_addr & INDEX_MASK;
                d.wdata  = cmd_wdata;
                d.issued = 1'b0;
                pb_clear = 1'b1;
            end
        end else if (t_fin) begin
            d.issued = 1'b0;
            case (q.state)
                ST_WAIT_TX_A, ST_WAIT_TX_D: begin
                    if (!tx_pend) begin
                        pb_clear = 1'b1;
                        d.state  = (q.state == ST_WAIT_TX_A) ? ST_PUT_ADDR : ST_PUT_DATA;
                    end else if (pb_last) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                        d.err   = 1'b1;
                        d.rdata = '0;
                    end else begin
                        pb_miss = 1'b1;
                    end
                end
                ST_PUT_ADDR: begin
                    pb_clear = 1'b1;
                    d.state  = q.wr ? ST_WAIT_TX_D : ST_WAIT_RX;
                end
                ST_PUT_DATA: begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                    d.rdata = '0;
                end
                ST_WAIT_RX: begin
                    if (rx_rdy) begin
                        pb_clear = 1'b1;
                        d.state  = ST_GET_DATA;
                    end else if (pb_last) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                        d.err   = 1'b1;
                        d.rdata = '0;
                    end else begin
                        pb_miss = 1'b1;
                    end
                end
                ST_GET_DATA: begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                    d.rdata = bus_rsp_rdata;
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, issued: 1'b0, wr: 1'b0, vaddr: '0,
                   wdata: '0, rdata: '0, done: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/vra_sequencer_chk.sv
module vra_sequencer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              done,
    input logic              done_err,
    input logic              bus_req_valid,
    input logic              bus_req_ready,
    input logic              bus_req_write,
    input logic [7:0]        bus_req_addr,
    input logic [DATA_W-1:0] bus_req_wdata,
    input logic              bus_rsp_valid
);
    logic outstanding_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outstanding_q <= 1'b0;
        end else if (bus_req_valid && bus_req_ready) begin
            outstanding_q <= 1'b1;
        end else if (bus_rsp_valid) begin
            outstanding_q <= 1'b0;
        end
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
            && $stable(bus_req_write) && $stable(bus_req_wdata));

    assert_reg_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> bus_req_addr <= 8'h02);

    assert_write_only_inbound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_req_write |-> bus_req_addr == 8'h01);

    assert_read_not_inbound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_req_write |-> bus_req_addr != 8'h01);

    assert_no_req_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !bus_req_valid);

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_ready);

    assert_ready_returns_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> done);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_only_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> done);

    assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> !outstanding_q);
endmodule

bind vra_sequencer vra_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .done          (done),
    .done_err      (done_err),
    .bus_req_valid (bus_req_valid),
    .bus_req_ready (bus_req_ready),
    .bus_req_write (bus_req_write),
    .bus_req_addr  (bus_req_addr),
    .bus_req_wdata (bus_req_wdata),
    .bus_rsp_valid (bus_rsp_valid)
);

// File: tb/vra_sequencer_bench.sv
module vra_sequencer_bench;
    localparam int M = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       done, done_err;
    logic [7:0] rdata;
    logic       bus_req_valid, bus_req_write;
    logic [7:0] bus_req_addr, bus_req_wdata;
    logic       bus_req_ready = 1'b0;
    logic       bus_rsp_valid = 1'b0;
    logic [7:0] bus_rsp_rdata = '0;

    always #2 clk = ~clk;

    vra_sequencer #(.MAX_POLLS(M), .DATA_W(8)) u_vra_sequencer (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .done(done), .done_err(done_err), .rdata(rdata),
        .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
        .bus_req_write(bus_req_write), .bus_req_addr(bus_req_addr),
        .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid),
        .bus_rsp_rdata(bus_rsp_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural sensor target ----------------
    logic [7:0] tmem   [0:127];
    logic [7:0] shadow [0:127];
    int  tx_cnt = 0, rx_cnt = 0, knob_tx_after = 0, knob_rx_delay = 0;
    bit  rx_armed = 0, wr_armed = 0, bp_en = 0;
    logic [6:0] rx_idx = '0, wr_idx = '0;
    int  stat_reads = 0, pend = -1, cyc = 0;
    logic [7:0] rsp_hold = '0;

    initial begin
        for (int i = 0; i < 128; i++) begin
            tmem[i]   = 8'(i * 7 + 3);
            shadow[i] = 8'(i * 7 + 3);
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        bus_req_ready <= bp_en ? (cyc % 3 == 0) : 1'b1;
        bus_rsp_valid <= 1'b0;
        if (pend > 0) begin
            pend = pend - 1;
        end else if (pend == 0) begin
            bus_rsp_valid <= 1'b1;
            bus_rsp_rdata <= rsp_hold;
            pend = -1;
        end
        if (rst_n && bus_req_valid && bus_req_ready) begin
            if (bus_req_write) begin
                if (bus_req_addr != 8'h01) chk(0, "R2 write target", bus_req_addr, 1);
                if (tx_cnt != 0) chk(0, "R3 write while pending", tx_cnt, 0);
                if (wr_armed) begin
                    tmem[wr_idx] = bus_req_wdata;
                    wr_armed = 0;
                end else if (bus_req_wdata[7]) begin
                    wr_armed = 1;
                    wr_idx = bus_req_wdata[6:0];
                end else begin
                    rx_armed = 1;
                    rx_idx = bus_req_wdata[6:0];
                    rx_cnt = knob_rx_delay;
                end
                tx_cnt = knob_tx_after;
                rsp_hold = '0;
            end else if (bus_req_addr == 8'h00) begin
                stat_reads = stat_reads + 1;
                rsp_hold = {6'b0, tx_cnt != 0, rx_armed && rx_cnt == 0};
                if (tx_cnt > 0) tx_cnt = tx_cnt - 1;
                if (rx_armed && rx_cnt > 0) rx_cnt = rx_cnt - 1;
            end else if (bus_req_addr == 8'h02) begin
                if (!(rx_armed && rx_cnt == 0)) chk(0, "R5 early outbound read", 0, 1);
                rsp_hold = tmem[rx_idx];
                rx_armed = 0;
            end else begin
                chk(0, "R2 bad address", bus_req_addr, 0);
            end
            pend = bp_en ? 1 : 0;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit         err;
        logic [7:0] data;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req_valid && cmd_ready) chk(0, "R7 request while idle", 1, 0);
            if (done_err && !done) chk(0, "R9 err without done", 1, 0);
            if (done) begin
                chk(cmd_ready == 1'b1, "R8 ready in done cycle", cmd_ready, 1);
                if (sbq.size() == 0) begin
                    chk(0, "R9 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(done_err == e.err, {e.tag, " err flag"}, done_err, e.err);
                    chk(rdata == e.data, {e.tag, " rdata"}, rdata, e.data);
                end
            end
        end
    end

    task automatic send(input bit wr, input logic [7:0] addr, input logic [7:0] data,
                        input bit exp_err, input string tag);
        exp_t e;
        e.err  = exp_err;
        e.tag  = tag;
        e.data = (wr || exp_err) ? 8'h00 : shadow[addr[6:0]];
        if (wr && !exp_err) shadow[addr[6:0]] = data;
        sbq.push_back(e);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_addr  = addr;
        cmd_wdata = data;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic release_cmd();
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_all();
        while (sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_target(input int tx_now, input int tx_after, input int rx_delay, input bit bp);
        @(negedge clk);
        tx_cnt = tx_now;
        knob_tx_after = tx_after;
        knob_rx_delay = rx_delay;
        rx_armed = 0;
        wr_armed = 0;
        bp_en = bp;
        stat_reads = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(bus_req_valid == 1'b0, "R1 bus_req_valid", bus_req_valid, 0);
        rst_n = 1'b1;

        // R4: plain write, one status poll per wait
        set_target(0, 0, 0, 0);
        send(1, 8'h12, 8'hA5, 0, "R4 write");
        release_cmd();
        wait_all();
        chk(tmem[7'h12] == 8'hA5, "R4 target memory", tmem[7'h12], 8'hA5);
        chk(stat_reads == 2, "R3 status reads for write", stat_reads, 2);

        // R5: plain read
        set_target(0, 0, 0, 0);
        send(0, 8'h12, 8'h00, 0, "R5 read back");
        release_cmd();
        wait_all();
        chk(stat_reads == 2, "R5 status reads for read", stat_reads, 2);

        // R3/R5: pending status persisting for several reads
        set_target(2, 1, 2, 0);
        send(1, 8'h33, 8'h5C, 0, "R3 write with busy target");
        release_cmd();
        wait_all();
        chk(stat_reads == 5, "R3 polls across two waits", stat_reads, 5);
        send(0, 8'h33, 8'h00, 0, "R5 read with delayed outbound");
        release_cmd();
        wait_all();

        // R6: bit 7 of the address input ignored
        set_target(0, 0, 0, 0);
        send(1, 8'h85, 8'h3E, 0, "R6 write masked");
        release_cmd();
        wait_all();
        chk(tmem[7'h05] == 8'h3E, "R6 masked index", tmem[7'h05], 8'h3E);
        send(0, 8'h85, 8'h00, 0, "R6 read masked");
        release_cmd();
        wait_all();

        // R2: back-pressure on the request port
        set_target(1, 1, 1, 1);
        send(1, 8'h40, 8'hC3, 0, "R2 write under backpressure");
        release_cmd();
        wait_all();
        send(0, 8'h40, 8'h00, 0, "R2 read under backpressure");
        release_cmd();
        wait_all();

        // R7: readiness on the last allowed poll succeeds
        set_target(M - 1, 0, 0, 0);
        send(1, 8'h50, 8'h77, 0, "R7 ready on last poll");
        release_cmd();
        wait_all();
        chk(stat_reads == M + 1, "R7 polls at limit", stat_reads, M + 1);

        // R7: first wait exhausted
        set_target(M, 0, 0, 0);
        send(1, 8'h51, 8'h99, 1, "R7 abort first wait");
        release_cmd();
        wait_all();
        chk(stat_reads == M, "R7 polls before abort", stat_reads, M);
        chk(tmem[7'h51] == shadow[7'h51], "R7 memory untouched", tmem[7'h51], shadow[7'h51]);

        // R7: second wait of a write exhausted
        set_target(0, M, 0, 0);
        send(1, 8'h52, 8'h98, 1, "R7 abort data wait");
        release_cmd();
        wait_all();
        chk(stat_reads == M + 1, "R7 budget restarts per wait", stat_reads, M + 1);
        chk(tmem[7'h52] == shadow[7'h52], "R7 data never sent", tmem[7'h52], shadow[7'h52]);

        // R7: outbound wait at limit and beyond
        set_target(0, 0, M - 1, 0);
        send(0, 8'h50, 8'h00, 0, "R7 outbound on last poll");
        release_cmd();
        wait_all();
        set_target(0, 0, M, 0);
        send(0, 8'h50, 8'h00, 1, "R7 outbound abort");
        release_cmd();
        wait_all();
        chk(stat_reads == M + 1, "R7 polls before read abort", stat_reads, M + 1);

        // R8: back-to-back commands with valid held
        set_target(0, 0, 0, 0);
        send(1, 8'h20, 8'h11, 0, "R8 b2b write");
        send(0, 8'h20, 8'h00, 0, "R8 b2b read");
        send(1, 8'h21, 8'h22, 0, "R8 b2b write 2");
        release_cmd();
        wait_all();
        chk(tmem[7'h21] == 8'h22, "R8 last command effect", tmem[7'h21], 8'h22);
        chk(sbq.size() == 0, "R9 one done per command", sbq.size(), 0);

        finish_run();
    end
endmodule